// File: doc/BRIEF.md
# Pixel Column Priority Hit Readout

This block collects hits from a column of pixel readout cells that share one output bus. Each cell watches its already synchronised discriminator level and records a hit when that level rises. At that moment it captures the column's running 8-bit timestamp next to its own fixed address. A priority chain lets one waiting cell at a time place its timestamp and address on the shared bus. Once per word period, end-of-column logic takes the word, clears the cell that supplied it, and loads the two halves into two shift registers. One shift register sends the timestamp and the other sends the address.

The block runs on one bit clock. A phase counter divides it by the serialisation ratio (8) to form the word-period tick. All cell sampling, arbitration and timestamp counting advance on that tick, and the two serial lanes shift one bit on every bit clock. A frame strobe marks the first bit of each word. A valid flag shows whether that word carries a hit or is an idle slot.

Top module: `pixcol_hit_readout`

## Requirements
- R1: A cell records a hit only when its discriminator input, sampled at a word tick, is high after being low at the previous tick. A level that stays high does not record another hit.
- R2: A recorded hit carries the value the timestamp counter held at the tick in which the rising edge was sampled.
- R3: Each cell's address is ADDR_BASE plus its index (0x10 + index with the default settings) and is sent together with that cell's stored timestamp.
- R4: Of all pending cells, the one with the lowest index is read first. Exactly one word is read per tick. A hit recorded at tick t can be read at tick t+1 at the earliest, and the next pending cell is read at the following tick.
- R5: While a cell holds an unread hit and is not being read, further rising edges on its input are ignored and its stored timestamp does not change.
- R6: If a rising edge arrives at the same tick in which the cell is read, the cell keeps a new hit stamped with that tick's timestamp.
- R7: The timestamp counter advances by one per tick and wraps from 255 to 0.
- R8: After each tick, each lane sends its 8-bit word MSB first, one bit per bit clock. The frame output is high only on the first bit. If no cell was pending at the tick, valid is low and both lanes send zeros.
- R9: A synchronous active-high reset clears all pending hits, the timestamp counter, the phase counter and both shift registers. The timestamp restarts at 0 after reset.
- R10: The priority chain never grants the bus to more than one cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; the word tick is every SER_RATIO-th cycle |
| rst | input | 1 | Synchronous active-high reset |
| disc_in | input | N_CELLS | Synchronised discriminator levels, one per cell |
| ts_sout | output | 1 | Timestamp serial lane, MSB first |
| addr_sout | output | 1 | Address serial lane, MSB first |
| word_frame | output | 1 | High on the first bit of each serial word |
| word_valid | output | 1 | High for the whole word when it carries a hit |

## Verification
The assertions check on every cycle that at most one cell holds the grant, that a pending lowest-index request is always granted, and that an unread hit keeps its stored timestamp. They also check that each lane shifts MSB first, that idle slots send zeros with valid low, and that the counter wraps. Some behaviours only the bench's scenarios can show: the full order in which several simultaneous hits drain, the one-tick latency from an edge to its read, an edge that is ignored behind a queue compared with one that is kept at the clearing tick, and the timestamp restarting from zero after a reset in the middle of a run.

// File: rtl/pixcol_pkg.sv
package pixcol_pkg;
   localparam int DEF_TS_W   = 8;
   localparam int DEF_ADDR_W = 8;

   // fixed address of a cell: base offset plus column position
   function automatic logic [31:0] cell_addr(input int base, input int idx);
      return 32'(base + idx);
   endfunction
endpackage

// File: rtl/pixcol_cell.sv
module pixcol_cell #(
   parameter int TS_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic            disc,
   input  logic            clr,
   input  logic [TS_W-1:0] ts_now,
   output logic            pend,
   output logic [TS_W-1:0] ts_hold
);
   logic disc_q;
   logic rise;

   assign rise = tick & disc & ~disc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         disc_q  <= 1'b0;
         pend    <= 1'b0;
         ts_hold <= '0;
      end else if (tick) begin
         disc_q <= disc;
         if (rise && (!pend || clr)) begin
            pend    <= 1'b1;
            ts_hold <= ts_now;
         end else if (clr) begin
            pend <= 1'b0;
         end
      end
   end

   // R5: an unread hit that is not being served keeps its timestamp
   a_r5_hold_ts: assert property (@(posedge clk) disable iff (rst)
      (pend && !clr) |=> (ts_hold == $past(ts_hold)));

   // R6: edge at the clearing tick leaves a fresh hit
   a_r6_rehit: assert property (@(posedge clk) disable iff (rst)
      (tick && clr && disc && !disc_q) |=> (pend && ts_hold == $past(ts_now)));

   // R1: a held-high level does not create a hit
   a_r1_level_only: assert property (@(posedge clk) disable iff (rst)
      (tick && disc && disc_q && !pend) |=> !pend);
endmodule

// File: rtl/pixcol_prio_chain.sv
module pixcol_prio_chain #(
   parameter int N_CELLS = 8,
   parameter int WORD_W  = 16
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [N_CELLS-1:0]             req,
   input  logic [N_CELLS-1:0][WORD_W-1:0] data,
   output logic [N_CELLS-1:0]             grant,
   output logic [WORD_W-1:0]              bus
);
   logic [N_CELLS:0]             free;
   logic [N_CELLS:0][WORD_W-1:0] acc;

   assign free[0] = 1'b1;
   assign acc[0]  = '0;

   for (genvar i = 0; i < N_CELLS; i++) begin : g_link
      assign grant[i]  = req[i] & free[i];
      assign free[i+1] = free[i] & ~req[i];
      assign acc[i+1]  = acc[i] | (data[i] & {WORD_W{grant[i]}});
   end

   assign bus = acc[N_CELLS];

   // R10: never two drivers on the shared bus
   a_r10_one_driver: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

   // R4: any pending request yields a grant; index 0 wins when pending
   a_r4_served: assert property (@(posedge clk) disable iff (rst)
      (|req) |-> (|grant));
   a_r4_top_wins: assert property (@(posedge clk) disable iff (rst)
      req[0] |-> grant[0]);
endmodule

// File: rtl/pixcol_serializer.sv
module pixcol_serializer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         sout
);
   logic [W-1:0] sr;

   if (W < 2) begin : g_bad_w
      $error("pixcol_serializer: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)       sr <= '0;
      else if (load) sr <= din;
      else           sr <= {sr[W-2:0], 1'b0};
   end

   assign sout = sr[W-1];

   // R8: MSB leaves first, following bits move up one place per clock
   a_r8_msb_first: assert property (@(posedge clk) disable iff (rst)
      load |=> (sout == $past(din[W-1])));
   a_r8_shift: assert property (@(posedge clk) disable iff (rst)
      !load |=> (sr[W-1] == $past(sr[W-2])));
endmodule

// File: rtl/pixcol_hit_readout.sv
module pixcol_hit_readout
   import pixcol_pkg::*;
#(
   parameter int N_CELLS   = 8,
   parameter int TS_W      = DEF_TS_W,
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int SER_RATIO = 8,
   parameter int ADDR_BASE = 16
) (
   input  logic               clk_bit,
   input  logic               rst,
   input  logic [N_CELLS-1:0] disc_in,
   output logic               ts_sout,
   output logic               addr_sout,
   output logic               word_frame,
   output logic               word_valid
);
   localparam int WORD_W = TS_W + ADDR_W;
   localparam int PH_W   = (SER_RATIO > 1) ? $clog2(SER_RATIO) : 1;

   if (SER_RATIO != TS_W || SER_RATIO != ADDR_W) begin : g_bad_ratio
      $error("pixcol_hit_readout: SER_RATIO must equal TS_W and ADDR_W");
   end
   if (N_CELLS < 1 || ADDR_BASE + N_CELLS > (1 << ADDR_W)) begin : g_bad_addr
      $error("pixcol_hit_readout: cell addresses do not fit ADDR_W");
   end

   logic [PH_W-1:0]                ph;
   logic                           tick;
   logic [TS_W-1:0]                ts_cnt;
   logic [N_CELLS-1:0]             pend_vec;
   logic [N_CELLS-1:0]             grant;
   logic [N_CELLS-1:0]             clr_vec;
   logic [N_CELLS-1:0][WORD_W-1:0] cell_word;
   logic [WORD_W-1:0]              bus;
   logic                           any_pend;
   logic [TS_W-1:0]                ts_load;
   logic [ADDR_W-1:0]              addr_load;

   assign tick = (ph == PH_W'(SER_RATIO - 1));

   always_ff @(posedge clk_bit) begin
      if (rst) begin
         ph         <= '0;
         ts_cnt     <= '0;
         word_frame <= 1'b0;
         word_valid <= 1'b0;
      end else begin
         ph         <= tick ? '0 : ph + 1'b1;
         word_frame <= tick;
         if (tick) begin
            ts_cnt     <= ts_cnt + 1'b1;
            word_valid <= any_pend;
         end
      end
   end

   assign clr_vec = grant & {N_CELLS{tick}};

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      logic [TS_W-1:0] ts_i;
      pixcol_cell #(.TS_W(TS_W)) u_cell (
         .clk     (clk_bit),
         .rst     (rst),
         .tick    (tick),
         .disc    (disc_in[i]),
         .clr     (clr_vec[i]),
         .ts_now  (ts_cnt),
         .pend    (pend_vec[i]),
         .ts_hold (ts_i)
      );
      assign cell_word[i] = {ts_i, ADDR_W'(cell_addr(ADDR_BASE, i))};
   end

   pixcol_prio_chain #(.N_CELLS(N_CELLS), .WORD_W(WORD_W)) u_chain (
      .clk   (clk_bit),
      .rst   (rst),
      .req   (pend_vec),
      .data  (cell_word),
      .grant (grant),
      .bus   (bus)
   );

   assign any_pend  = |pend_vec;
   assign ts_load   = any_pend ? bus[WORD_W-1 -: TS_W] : '0;
   assign addr_load = any_pend ? bus[ADDR_W-1:0]       : '0;

   pixcol_serializer #(.W(TS_W)) u_ser_ts (
      .clk  (clk_bit),
      .rst  (rst),
      .load (tick),
      .din  (ts_load),
      .sout (ts_sout)
   );

   pixcol_serializer #(.W(ADDR_W)) u_ser_addr (
      .clk  (clk_bit),
      .rst  (rst),
      .load (tick),
      .din  (addr_load),
      .sout (addr_sout)
   );

   // R7: counter wraps from all-ones to zero at a tick
   a_r7_wrap: assert property (@(posedge clk_bit) disable iff (rst)
      (tick && ts_cnt == '1) |=> (ts_cnt == '0));

   // R8: frame lasts a single bit
   a_r8_frame_once: assert property (@(posedge clk_bit) disable iff (rst)
      word_frame |=> !word_frame);

   // R8: idle slot sends zeros with valid low
   a_r8_idle_zero: assert property (@(posedge clk_bit) disable iff (rst)
      (tick && pend_vec == '0) |=> (!word_valid && !ts_sout && !addr_sout && word_frame));
endmodule

// File: tb/pixcol_hit_readout_bench.sv
module pixcol_hit_readout_bench;
   localparam int NC = 8;
   localparam int NROWS = 19;

   logic          clk_bit = 1'b0;
   logic          rst = 1'b1;
   logic [NC-1:0] disc_in = '0;
   logic          ts_sout, addr_sout, word_frame, word_valid;

   int n_run = 0;
   int n_fail = 0;
   int tick_no = 0;
   bit done = 1'b0;

   always #10 clk_bit = ~clk_bit;

   pixcol_hit_readout u_pixcol_hit_readout (
      .clk_bit    (clk_bit),
      .rst        (rst),
      .disc_in    (disc_in),
      .ts_sout    (ts_sout),
      .addr_sout  (addr_sout),
      .word_frame (word_frame),
      .word_valid (word_valid)
   );

   // {disc for this tick, expected valid, addr, ts of the word read at the previous tick}
   localparam logic [24:0] VEC [NROWS] = '{
      {8'h05, 1'b0, 8'h00, 8'h00},  // cells 0 and 2 rise, ts 1
      {8'h05, 1'b0, 8'h00, 8'h00},  // held high: R1 no new hit
      {8'h04, 1'b1, 8'h10, 8'h01},  // R4 cell 0 first
      {8'h84, 1'b1, 8'h12, 8'h01},  // cell 2 next; cell 7 rises ts 4
      {8'h04, 1'b0, 8'h00, 8'h00},  // R1 nothing left from held levels
      {8'h02, 1'b1, 8'h17, 8'h04},  // cell 7; cell 1 rises ts 6
      {8'h0A, 1'b0, 8'h00, 8'h00},  // cell 3 rises ts 7
      {8'h09, 1'b1, 8'h11, 8'h06},  // cell 1; cell 0 rises ts 8
      {8'h08, 1'b1, 8'h13, 8'h07},
      {8'h26, 1'b1, 8'h10, 8'h08},  // cells 1, 2, 5 rise ts 10
      {8'h06, 1'b0, 8'h00, 8'h00},
      {8'h26, 1'b1, 8'h11, 8'h0A},  // cell 5 re-rises while queued: R5
      {8'h06, 1'b1, 8'h12, 8'h0A},
      {8'h1E, 1'b1, 8'h15, 8'h0A},  // R5 cell 5 keeps ts 10; cells 3,4 rise ts 14
      {8'h0E, 1'b0, 8'h00, 8'h00},
      {8'h1E, 1'b1, 8'h13, 8'h0E},  // cell 4 rises at its clearing tick: R6
      {8'h00, 1'b1, 8'h14, 8'h0E},
      {8'h00, 1'b1, 8'h14, 8'h10},  // R6 fresh hit ts 16
      {8'h00, 1'b0, 8'h00, 8'h00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one word period: sample 8 bits at negedges, the last wait covers the tick
   task automatic slow(input logic [NC-1:0] d, output logic [7:0] ts_w,
                       output logic [7:0] ad_w, output logic v, output logic fr_ok);
      disc_in = d;
      fr_ok = 1'b1;
      v = word_valid;
      for (int k = 0; k < 8; k++) begin
         ts_w = {ts_w[6:0], ts_sout};
         ad_w = {ad_w[6:0], addr_sout};
         if (word_frame !== (k == 0)) fr_ok = 1'b0;
         if (word_valid !== v) fr_ok = 1'b0;
         @(negedge clk_bit);
      end
      tick_no++;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] tw, aw;
      logic v, fok;
      repeat (4) @(negedge clk_bit);
      // R9 reset state
      check("R9 reset outputs", {28'd0, ts_sout, addr_sout, word_frame, word_valid}, 32'd0);
      rst = 1'b0;
      slow('0, tw, aw, v, fok);

      for (int r = 0; r < NROWS; r++) begin
         slow(VEC[r][24:17], tw, aw, v, fok);
         check($sformatf("R4/R8 row %0d valid", r), {31'd0, v}, {31'd0, VEC[r][16]});
         check($sformatf("R3 row %0d addr", r), {24'd0, aw}, {24'd0, VEC[r][15:8]});
         check($sformatf("R2 row %0d ts", r), {24'd0, tw}, {24'd0, VEC[r][7:0]});
         check($sformatf("R8 row %0d frame", r), {31'd0, fok}, 32'd1);
      end

      // R7 wrap: hits stamped 255 and 0
      while (tick_no < 255) slow('0, tw, aw, v, fok);
      slow(8'h01, tw, aw, v, fok);
      slow(8'h02, tw, aw, v, fok);
      slow(8'h00, tw, aw, v, fok);
      check("R7 ts before wrap", {23'd0, v, tw}, {23'd0, 1'b1, 8'hFF});
      slow(8'h00, tw, aw, v, fok);
      check("R7 ts after wrap", {23'd0, v, tw}, {23'd0, 1'b1, 8'h00});
      check("R3 wrap addr", {24'd0, aw}, 32'h11);

      // R9 reset in mid-run with cell 1 still pending
      slow(8'h03, tw, aw, v, fok);
      slow(8'h00, tw, aw, v, fok);
      rst = 1'b1;
      repeat (3) @(negedge clk_bit);
      check("R9 outputs under reset", {28'd0, ts_sout, addr_sout, word_frame, word_valid}, 32'd0);
      rst = 1'b0;
      tick_no = 0;
      slow('0, tw, aw, v, fok);
      slow(8'h01, tw, aw, v, fok);
      check("R9 pending cleared", {31'd0, v}, 32'd0);
      slow(8'h00, tw, aw, v, fok);
      check("R9 still idle", {31'd0, v}, 32'd0);
      slow(8'h00, tw, aw, v, fok);
      check("R9 ts restarts", {15'd0, v, aw, tw}, {15'd0, 1'b1, 8'h10, 8'h01});
      check("R10 single word framed", {31'd0, fok}, 32'd1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule